// File: doc/BRIEF.md
# Dual-Unit Round-Robin Issue Steering

This block sits at the issue point of a small two-unit execution cluster. Each cycle it may accept one operation, described only by a three-bit class code. It decides which of the two execution units (unit 0 and unit 1) receives it and reports the result latency. Operations that either unit can run follow a turn pointer that alternates between the units. Classes that belong to one unit still move the turn to the other unit, so the alternation keeps working when pinned and flexible operations are mixed.

Each unit has an occupancy counter. Multiply, divide and the two-step compound class keep a unit reserved for cycles after the issue cycle. The input ready signal is computed in the same cycle from the class on the input and the counters, so an operation that cannot be placed waits at the input. Grants are combinational: when valid and ready are both high, the grant outputs describe that same operation in that same cycle.

Top module: `dual_issue_steer`

## Requirements
- R1: After reset both units are idle and the turn points to unit 0. Every class code is ready, and the first flexible operation goes to unit 0.
- R2: A flexible operation (class 0, latency 2) goes to the unit that holds the turn when that unit is free. The turn then passes to the other unit.
- R3: When the turn unit is busy and the other unit is free, a flexible operation goes to the free unit and the turn passes away from the unit actually used. A flexible operation is never held while one unit is free.
- R4: Class 1 (branch-like) always goes to unit 0 with latency 2 and passes the turn to unit 1.
- R5: Class 2 (multiply) goes to unit 1 with latency 5. It keeps unit 1 reserved for one cycle after the issue cycle, so classes pinned to unit 1 are not ready in that cycle. It passes the turn to unit 0.
- R6: Class 3 (divide/remainder) goes to unit 1 with latency 20. It keeps unit 1 reserved for 18 cycles after the issue cycle, and passes the turn to unit 0.
- R7: Class 4 (two-step) has latency 4. It uses a first unit in the issue cycle and the other unit in the next cycle. The turn unit is tried first as the first unit, and the reverse order is used when only that order fits. grant_unit reports the first unit, and the turn passes away from it.
- R8: Class codes 5, 6 and 7 are unrecognised. They need both units free and reserve both for the issue cycle only. They report grant_dual=1, grant_unit=0 and latency 1, and leave the turn unchanged.
- R9: The turn changes only on a cycle with op_valid and op_ready both high. An operation held at the input leaves it unchanged.
- R10: grant_valid is high exactly when op_valid and op_ready are both high. grant_unit=0 names unit 0 and 1 names unit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_class | input | 3 | Operation class: 0 flexible, 1 branch, 2 multiply, 3 divide, 4 two-step, 5-7 unrecognised |
| op_ready | output | 1 | The presented class can issue this cycle |
| grant_valid | output | 1 | An operation issues this cycle |
| grant_unit | output | 1 | Unit receiving the operation (first unit for two-step) |
| grant_dual | output | 1 | Both units reserved (unrecognised class) |
| grant_latency | output | 5 | Cycles until the result is available |

## Verification
A corrupted turn pointer shows at the next flexible issue as a wrong grant_unit, so the bench places flexible operations directly after every pinned, compound and stalled issue. A wrong occupancy count shows as op_ready rising one or more cycles early or late. The bench therefore samples ready for a unit-1 class on every cycle of the divide window and on the cycle after a multiply. It also counts the exact stall length of an unrecognised operation held behind a divide.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_UNITS = 2;
    localparam int LAT_W     = 5;
    localparam int HOLD_W    = 5;

    typedef enum logic [2:0] {
        CLS_FLEX    = 3'd0,
        CLS_BRANCH  = 3'd1,
        CLS_MUL     = 3'd2,
        CLS_DIV     = 3'd3,
        CLS_PAIR    = 3'd4,
        CLS_RSV5    = 3'd5,
        CLS_RSV6    = 3'd6,
        CLS_UNKNOWN = 3'd7
    } op_cls_e;

    typedef enum logic [2:0] {
        PL_FLEX   = 3'd0,
        PL_FIXED0 = 3'd1,
        PL_FIXED1 = 3'd2,
        PL_SPLIT  = 3'd3,
        PL_ALL    = 3'd4
    } place_e;

    typedef struct packed {
        place_e             place;
        logic [HOLD_W-1:0]  hold;
        logic [LAT_W-1:0]   lat;
    } op_attr_t;

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } unit_state_t;

    typedef struct packed {
        logic turn;
    } turn_state_t;

endpackage

// File: rtl/steer_decode.sv
module steer_decode
    import steer_pkg::*;
#(
    parameter logic [LAT_W-1:0]  LAT_FLEX   = 5'd2,
    parameter logic [LAT_W-1:0]  LAT_BRANCH = 5'd2,
    parameter logic [LAT_W-1:0]  LAT_MUL    = 5'd5,
    parameter logic [LAT_W-1:0]  LAT_DIV    = 5'd20,
    parameter logic [LAT_W-1:0]  LAT_PAIR   = 5'd4,
    parameter logic [LAT_W-1:0]  LAT_OTHER  = 5'd1,
    parameter logic [HOLD_W-1:0] HOLD_MUL   = 5'd1,
    parameter logic [HOLD_W-1:0] HOLD_DIV   = 5'd18
) (
    input  logic [2:0] cls_i,
    output op_attr_t   attr_o
);

    always_comb begin
        attr_o.place = PL_ALL;
        attr_o.hold  = '0;
        attr_o.lat   = LAT_OTHER;
        case (cls_i)
            CLS_FLEX: begin
                attr_o.place = PL_FLEX;
                attr_o.lat   = LAT_FLEX;
            end
            CLS_BRANCH: begin
                attr_o.place = PL_FIXED0;
                attr_o.lat   = LAT_BRANCH;
            end
            CLS_MUL: begin
                attr_o.place = PL_FIXED1;
                attr_o.hold  = HOLD_MUL;
                attr_o.lat   = LAT_MUL;
            end
            CLS_DIV: begin
                attr_o.place = PL_FIXED1;
                attr_o.hold  = HOLD_DIV;
                attr_o.lat   = LAT_DIV;
            end
            CLS_PAIR: begin
                attr_o.place = PL_SPLIT;
                attr_o.lat   = LAT_PAIR;
            end
            default: begin
                attr_o.place = PL_ALL;
                attr_o.lat   = LAT_OTHER;
            end
        endcase
    end

endmodule

// File: rtl/steer_pick.sv
module steer_pick
    import steer_pkg::*;
(
    input  op_attr_t                             attr_i,
    input  logic                                 turn_i,
    input  logic [NUM_UNITS-1:0]                 busy_now_i,
    input  logic [NUM_UNITS-1:0]                 free_next_i,
    output logic                                 can_go_o,
    output logic                                 first_o,
    output logic                                 dual_o,
    output logic [NUM_UNITS-1:0]                 claim_o,
    output logic [NUM_UNITS-1:0][HOLD_W-1:0]     claim_len_o,
    output logic                                 turn_after_o
);

    logic other;
    assign other = ~turn_i;

    always_comb begin
        can_go_o     = 1'b0;
        first_o      = 1'b0;
        dual_o       = 1'b0;
        claim_o      = '0;
        claim_len_o  = '0;
        turn_after_o = turn_i;
        case (attr_i.place)
            PL_FLEX: begin
                if (!busy_now_i[turn_i]) begin
                    can_go_o = 1'b1;
                    first_o  = turn_i;
                end else if (!busy_now_i[other]) begin
                    can_go_o = 1'b1;
                    first_o  = other;
                end
                claim_o[first_o]     = 1'b1;
                claim_len_o[first_o] = attr_i.hold;
                turn_after_o         = ~first_o;
            end
            PL_FIXED0: begin
                can_go_o       = !busy_now_i[0];
                first_o        = 1'b0;
                claim_o[0]     = 1'b1;
                claim_len_o[0] = attr_i.hold;
                turn_after_o   = 1'b1;
            end
            PL_FIXED1: begin
                can_go_o       = !busy_now_i[1];
                first_o        = 1'b1;
                claim_o[1]     = 1'b1;
                claim_len_o[1] = attr_i.hold;
                turn_after_o   = 1'b0;
            end
            PL_SPLIT: begin
                if (!busy_now_i[turn_i] && free_next_i[other]) begin
                    can_go_o = 1'b1;
                    first_o  = turn_i;
                end else if (!busy_now_i[other] && free_next_i[turn_i]) begin
                    can_go_o = 1'b1;
                    first_o  = other;
                end
                claim_o               = '1;
                claim_len_o[first_o]  = attr_i.hold;
                claim_len_o[~first_o] = HOLD_W'(1);
                turn_after_o          = ~first_o;
            end
            default: begin
                can_go_o     = !busy_now_i[0] && !busy_now_i[1];
                first_o      = 1'b0;
                dual_o       = 1'b1;
                claim_o      = '1;
                turn_after_o = turn_i;
            end
        endcase
    end

endmodule

// File: rtl/steer_occupancy.sv
module steer_occupancy
    import steer_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fire_i,
    input  logic [NUM_UNITS-1:0]             claim_i,
    input  logic [NUM_UNITS-1:0][HOLD_W-1:0] claim_len_i,
    output logic [NUM_UNITS-1:0]             busy_now_o,
    output logic [NUM_UNITS-1:0]             free_next_o,
    output logic [NUM_UNITS-1:0][HOLD_W-1:0] count_o
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_state_t st_d;
        unit_state_t st_q;

        always_comb begin
            st_d = st_q;
            if (fire_i && claim_i[u]) begin
                st_d.cnt = claim_len_i[u];
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - HOLD_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign busy_now_o[u]  = (st_q.cnt != '0);
        assign free_next_o[u] = (st_q.cnt <= HOLD_W'(1));
        assign count_o[u]     = st_q.cnt;

        // R6: a reservation drains by exactly one per idle cycle
        a_r6_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!(fire_i && claim_i[u]) && busy_now_o[u])
            |=> (count_o[u] == $past(count_o[u]) - HOLD_W'(1)));
    end

endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
    import steer_pkg::*;
#(
    parameter logic [LAT_W-1:0]  LAT_FLEX   = 5'd2,
    parameter logic [LAT_W-1:0]  LAT_BRANCH = 5'd2,
    parameter logic [LAT_W-1:0]  LAT_MUL    = 5'd5,
    parameter logic [LAT_W-1:0]  LAT_DIV    = 5'd20,
    parameter logic [LAT_W-1:0]  LAT_PAIR   = 5'd4,
    parameter logic [LAT_W-1:0]  LAT_OTHER  = 5'd1,
    parameter logic [HOLD_W-1:0] HOLD_MUL   = 5'd1,
    parameter logic [HOLD_W-1:0] HOLD_DIV   = 5'd18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_class,
    output logic             op_ready,
    output logic             grant_valid,
    output logic             grant_unit,
    output logic             grant_dual,
    output logic [LAT_W-1:0] grant_latency
);

    op_attr_t                             attr;
    logic                                 can_go;
    logic                                 first_unit;
    logic                                 dual;
    logic [NUM_UNITS-1:0]                 claim;
    logic [NUM_UNITS-1:0][HOLD_W-1:0]     claim_len;
    logic                                 turn_after;
    logic [NUM_UNITS-1:0]                 busy_now;
    logic [NUM_UNITS-1:0]                 free_next;
    logic [NUM_UNITS-1:0][HOLD_W-1:0]     occ_count;
    logic                                 fire;
    turn_state_t                          ts_d;
    turn_state_t                          ts_q;

    steer_decode #(
        .LAT_FLEX   (LAT_FLEX),
        .LAT_BRANCH (LAT_BRANCH),
        .LAT_MUL    (LAT_MUL),
        .LAT_DIV    (LAT_DIV),
        .LAT_PAIR   (LAT_PAIR),
        .LAT_OTHER  (LAT_OTHER),
        .HOLD_MUL   (HOLD_MUL),
        .HOLD_DIV   (HOLD_DIV)
    ) decode_i (
        .cls_i  (op_class),
        .attr_o (attr)
    );

    steer_pick pick_i (
        .attr_i       (attr),
        .turn_i       (ts_q.turn),
        .busy_now_i   (busy_now),
        .free_next_i  (free_next),
        .can_go_o     (can_go),
        .first_o      (first_unit),
        .dual_o       (dual),
        .claim_o      (claim),
        .claim_len_o  (claim_len),
        .turn_after_o (turn_after)
    );

    steer_occupancy occ_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .claim_i     (claim),
        .claim_len_i (claim_len),
        .busy_now_o  (busy_now),
        .free_next_o (free_next),
        .count_o     (occ_count)
    );

    assign fire          = op_valid && can_go;
    assign op_ready      = can_go;
    assign grant_valid   = fire;
    assign grant_unit    = first_unit;
    assign grant_dual    = dual;
    assign grant_latency = attr.lat;

    always_comb begin
        ts_d = ts_q;
        if (fire) begin
            ts_d.turn = turn_after;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    // R9: the turn holds on every cycle without a handshake
    a_r9_turn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_ready) |=> $stable(ts_q.turn));

    // R4: branch-like class lands on unit 0
    a_r4_branch_unit0: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && op_class == CLS_BRANCH) |-> (grant_unit == 1'b0));

    // R5: unit 1 stays reserved in the cycle after a multiply
    a_r5_mul_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && op_class == CLS_MUL) |=> busy_now[1]);

    // R6: divide loads the full reservation window on unit 1
    a_r6_div_window: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && op_class == CLS_DIV) |=> (occ_count[1] == HOLD_DIV));

    // R3: the unit reported as first is never a busy unit
    a_r3_first_free: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !busy_now[grant_unit]);

    // R8: a dual reservation requires both units idle
    a_r8_dual_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_dual) |-> (busy_now == '0));

    // R2: a flexible issue hands the turn to the other unit
    a_r2_turn_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && op_class == CLS_FLEX) |=> (ts_q.turn != $past(grant_unit)));

endmodule

// File: tb/dual_issue_steer_tb.sv
module dual_issue_steer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic       op_ready;
    logic       grant_valid;
    logic       grant_unit;
    logic       grant_dual;
    logic [4:0] grant_latency;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        logic  unit;
        int    lat;
        logic  dual;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    dual_issue_steer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_class      (op_class),
        .op_ready      (op_ready),
        .grant_valid   (grant_valid),
        .grant_unit    (grant_unit),
        .grant_dual    (grant_dual),
        .grant_latency (grant_latency)
    );

    task automatic report(input bit ok, input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Monitor: compares each grant against the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (grant_valid) begin
                if (exp_q.size() == 0) begin
                    report(1'b0, "R10", "unexpected grant", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    report(grant_unit == e.unit && grant_dual == e.dual && int'(grant_latency) == e.lat,
                           e.tag, "grant unit*100+dual*50+lat",
                           int'(grant_unit) * 100 + int'(grant_dual) * 50 + int'(grant_latency),
                           int'(e.unit) * 100 + int'(e.dual) * 50 + e.lat);
                end
            end
        end
    end

    // Driver: presents one operation, waits for the handshake, records expectation
    task automatic send(input logic [2:0] cls, input logic xu, input int xl, input logic xd,
                        input int xwait, input string tag);
        int waits;
        exp_t e;
        waits = 0;
        @(negedge clk);
        op_valid = 1'b1;
        op_class = cls;
        #3;
        while (!op_ready && waits < 100) begin
            @(negedge clk);
            #3;
            waits++;
        end
        e.unit = xu; e.lat = xl; e.dual = xd; e.tag = tag;
        exp_q.push_back(e);
        if (xwait >= 0) report(waits == xwait, tag, "stall cycles", waits, xwait);
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    // Probe ready for a class without issuing; consumes one cycle
    task automatic probe(input logic [2:0] cls, input logic xr, input string tag);
        @(negedge clk);
        op_valid = 1'b0;
        op_class = cls;
        #3;
        report(op_ready == xr, tag, "op_ready", int'(op_ready), int'(xr));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every class ready out of reset, no grant without valid
        for (int c = 0; c < 8; c++) probe(3'(c), 1'b1, "R1");
        report(grant_valid == 1'b0, "R10", "grant_valid idle", int'(grant_valid), 0);

        send(3'd0, 1'b0, 2, 1'b0, 0, "R1");   // turn 0 -> unit 0, turn 1
        send(3'd0, 1'b1, 2, 1'b0, 0, "R2");   // unit 1, turn 0
        send(3'd1, 1'b0, 2, 1'b0, 0, "R4");   // pinned 0, turn 1
        send(3'd1, 1'b0, 2, 1'b0, 0, "R4");   // pinned 0, turn 1
        send(3'd0, 1'b1, 2, 1'b0, 0, "R4");   // turn was handed to unit 1
        send(3'd2, 1'b1, 5, 1'b0, 0, "R5");   // multiply, turn 0
        probe(3'd2, 1'b0, "R5");              // unit 1 reserved one cycle
        probe(3'd2, 1'b1, "R5");              // free again
        send(3'd0, 1'b0, 2, 1'b0, 0, "R5");   // turn handed to unit 0
        send(3'd0, 1'b1, 2, 1'b0, 0, "R2");   // turn 0
        send(3'd4, 1'b0, 4, 1'b0, 0, "R7");   // two-step u0 then u1, turn 1
        send(3'd0, 1'b0, 2, 1'b0, 0, "R3");   // unit 1 busy -> unit 0, turn 1
        send(3'd0, 1'b1, 2, 1'b0, 0, "R3");   // turn 0
        send(3'd0, 1'b0, 2, 1'b0, 0, "R2");   // turn 1
        send(3'd4, 1'b1, 4, 1'b0, 0, "R7");   // two-step u1 then u0, turn 0
        send(3'd4, 1'b1, 4, 1'b0, 0, "R7");   // unit 0 busy: reverse order, turn 0
        send(3'd0, 1'b1, 2, 1'b0, 0, "R3");   // unit 0 busy -> unit 1, turn 0
        send(3'd0, 1'b0, 2, 1'b0, 0, "R2");   // turn 1
        send(3'd7, 1'b0, 1, 1'b1, 0, "R8");   // turn stays 1
        send(3'd0, 1'b1, 2, 1'b0, 0, "R8");   // proves turn kept, turn 0
        send(3'd5, 1'b0, 1, 1'b1, 0, "R8");
        send(3'd6, 1'b0, 1, 1'b1, 0, "R8");
        send(3'd0, 1'b0, 2, 1'b0, 0, "R8");   // turn still 0, now 1
        send(3'd3, 1'b1, 20, 1'b0, 0, "R6");  // divide, turn 0
        for (int k = 1; k <= 18; k++) begin
            if (k == 9) probe(3'd0, 1'b1, "R3");
            else        probe(3'd2, 1'b0, "R6");
        end
        probe(3'd2, 1'b1, "R6");
        send(3'd3, 1'b1, 20, 1'b0, 0, "R6");  // turn 0
        send(3'd7, 1'b0, 1, 1'b1, 18, "R9");  // held 18 cycles behind divide
        send(3'd0, 1'b0, 2, 1'b0, 0, "R9");   // stall left turn at 0

        repeat (3) @(negedge clk);
        report(exp_q.size() == 0, "R10", "pending grants", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule